// File: doc/BRIEF.md
# Reset cause status register

This block keeps one byte of state that tells software why the device last restarted or entered a low-power state. Single-cycle event pulses come in from the reset generators, the watchdog and the CPU: power-on reset, brown-out reset, watchdog expiry, sleep entry, watchdog restart, software reset instruction and configuration mismatch. Each pulse drives one or more flags.

The cause flags are active-low. Hardware pulls a flag to 0 when its cause happens. Software reads the byte, notes the cause, and writes 1 back to re-arm the flags it may write. The byte also holds an interrupt-priority enable that is driven straight out to the interrupt controller.

A regulator-enable input can mask the brown-out flag. A combinational output reports a brown-out, meaning the brown-out flag is low while the power-on flag is high. Every update takes effect on the clock edge after its pulse or write. The read port is combinational and has no side effects.

Top module: `rsc_status_reg`

## Requirements
- R1: Both the synchronous reset (rst_n low) and a pulse on ev_por load the power-up value 0x3C: bit 7=0, bit 6=0, bits 5..2=1, bit 1=0, bit 0=0. A pulse on ev_por overrides every other event and any write in that cycle.
- R2: Bit 6 always reads 0, and writing 1 to it has no effect.
- R3: Bit 7 (priority enable) is loaded from wr_data[7] on a write. It is never changed by hardware events except power-on, and prio_en_o always equals bit 7.
- R4: Bit 5 (configuration flag) goes to 0 after ev_cfgmis and returns to 1 only through a software write.
- R5: Bit 4 (software-reset flag) goes to 0 after ev_swrst and returns to 1 only through a software write.
- R6: Bit 3 (watchdog flag) goes to 0 after ev_wdt. It goes to 1 after ev_clrwdt or ev_sleep. If ev_wdt comes in the same cycle as either of those, the 0 wins.
- R7: Bit 2 (power-down flag) goes to 0 after ev_sleep and goes to 1 after ev_clrwdt. If both come in the same cycle, the 0 wins.
- R8: Software writes do not change bits 3 and 2.
- R9: Software may set or clear bit 1 (power-on flag) and bit 0 (brown-out flag). A pulse on ev_bor drives bit 0 to 0.
- R10: While vreg_en is 0, bit 0 reads 0 and writes to it are lost. It stays 0 after vreg_en returns to 1 until software writes it to 1.
- R11: brownout_o is 1 exactly when the read value of bit 0 is 0 and bit 1 is 1. It follows the read value with no extra delay.
- R12: A hardware clear event wins over a software write of 1 to the same bit in the same cycle.
- R13: An event or write changes rd_data from the first clock edge after it. A cycle with no event and no write leaves rd_data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_por | input | 1 | Power-on reset pulse |
| ev_bor | input | 1 | Brown-out reset pulse |
| ev_wdt | input | 1 | Watchdog expiry pulse |
| ev_sleep | input | 1 | Sleep entry pulse |
| ev_clrwdt | input | 1 | Watchdog restart pulse |
| ev_swrst | input | 1 | Software reset instruction pulse |
| ev_cfgmis | input | 1 | Configuration mismatch reset pulse |
| vreg_en | input | 1 | On-chip regulator enabled |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 8 | Software write data |
| rd_data | output | 8 | Current register value |
| prio_en_o | output | 1 | Interrupt priority enable |
| brownout_o | output | 1 | Derived brown-out indication |

## Verification
Every event pulse and write lands on the rising edge that ends its cycle. The stored value on rd_data and prio_en_o is therefore due one edge after the stimulus. brownout_o and the regulator mask on bit 0 follow the inputs combinationally. The driver changes inputs just after a falling edge and pushes the expected item just after the following rising edge. The monitor compares at the next falling edge, so each result is checked exactly one edge after its stimulus. No input moves between that edge and the compare.

// File: rtl/rsc_pkg.sv
// Package: shared constants and types for the reset cause status register.
// Assumes an 8-bit register. Bit positions are fixed because software decodes them.
package rsc_pkg;

    localparam int REG_W = 8;

    // Bit positions that software decodes.
    localparam int B_PRIO   = 7;
    localparam int B_UNUSED = 6;
    localparam int B_CFG    = 5;
    localparam int B_SWRST  = 4;
    localparam int B_WDT    = 3;
    localparam int B_PWRDN  = 2;
    localparam int B_POR    = 1;
    localparam int B_BOR    = 0;

    // Power-up value, software write rights and implemented bits.
    localparam logic [REG_W-1:0] INIT_VAL  = 8'h3C;
    localparam logic [REG_W-1:0] SW_MASK   = 8'hB3;
    localparam logic [REG_W-1:0] IMPL_MASK = 8'hBF;

    // Bundle of single-cycle event pulses.
    typedef struct packed {
        logic por;
        logic bor;
        logic wdt;
        logic sleep;
        logic clrwdt;
        logic swrst;
        logic cfgmis;
    } evt_t;

endpackage

// File: rtl/rsc_event_map.sv
// Module: maps the event pulses and the regulator state to per-bit
// clear, set and force-zero vectors.
// Assumes each event is a one-cycle pulse. Power-on is handled separately as the init input of every flag.
module rsc_event_map
    import rsc_pkg::*;
(
    input  evt_t             ev,
    input  logic             vreg_en,
    output logic [REG_W-1:0] hw_clr,
    output logic [REG_W-1:0] hw_set,
    output logic [REG_W-1:0] force_zero
);

    // Clear vector: the cause events drive their flags to 0.
    always_comb begin
        hw_clr          = '0;
        hw_clr[B_CFG]   = ev.cfgmis;
        hw_clr[B_SWRST] = ev.swrst;
        hw_clr[B_WDT]   = ev.wdt;
        hw_clr[B_PWRDN] = ev.sleep;
        hw_clr[B_BOR]   = ev.bor;
    end

    // Set vector: watchdog restart and sleep re-arm the status flags.
    always_comb begin
        hw_set          = '0;
        hw_set[B_WDT]   = ev.clrwdt | ev.sleep;
        hw_set[B_PWRDN] = ev.clrwdt;
    end

    // Force-zero vector: a disabled regulator holds the brown-out flag low.
    always_comb begin
        force_zero        = '0;
        force_zero[B_BOR] = ~vreg_en;
    end

endmodule

// File: rtl/rsc_flag_cell.sv
// Module: one storage bit with its update priority:
// reset/init, force-zero, hardware clear, software write, hardware set.
// Assumes the caller decodes which events apply. When IMPL is 0 the bit stays 0.
module rsc_flag_cell #(
    parameter logic INIT = 1'b0,
    parameter logic SW_W = 1'b0,
    parameter logic IMPL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic force_zero,
    input  logic hw_clr,
    input  logic hw_set,
    input  logic sw_we,
    input  logic sw_d,
    output logic q
);

    logic nxt;

    // Next-state selection in priority order.
    always_comb begin
        if (init)                    nxt = INIT;
        else if (force_zero)         nxt = 1'b0;
        else if (hw_clr)             nxt = 1'b0;
        else if (sw_we && SW_W)      nxt = sw_d;
        else if (hw_set)             nxt = 1'b1;
        else                         nxt = q;
    end

    // Storage with synchronous active-low reset to the power-up value.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= IMPL ? INIT : 1'b0;
        else        q <= IMPL ? nxt  : 1'b0;
    end

endmodule

// File: rtl/rsc_readout.sv
// Module: builds the software-visible value and the brown-out indication.
// Assumes the stored bits come from the flag cells. Bit 0 is masked live by the regulator enable.
module rsc_readout
    import rsc_pkg::*;
(
    input  logic [REG_W-1:0] state,
    input  logic             vreg_en,
    output logic [REG_W-1:0] rd_data,
    output logic             prio_en_o,
    output logic             brownout_o
);

    // Read value with the unimplemented bit zeroed and bit 0 masked.
    always_comb begin
        rd_data        = state & IMPL_MASK;
        rd_data[B_BOR] = state[B_BOR] & vreg_en;
    end

    // Priority enable and derived brown-out indication.
    always_comb begin
        prio_en_o  = rd_data[B_PRIO];
        brownout_o = ~rd_data[B_BOR] & rd_data[B_POR];
    end

endmodule

// File: rtl/rsc_status_reg.sv
// Module: top of the reset cause status register.
// Assumes event inputs are synchronous one-cycle pulses and wr_en is a one-cycle write strobe.
module rsc_status_reg
    import rsc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_por,
    input  logic             ev_bor,
    input  logic             ev_wdt,
    input  logic             ev_sleep,
    input  logic             ev_clrwdt,
    input  logic             ev_swrst,
    input  logic             ev_cfgmis,
    input  logic             vreg_en,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             prio_en_o,
    output logic             brownout_o
);

    evt_t             ev;
    logic [REG_W-1:0] hw_clr;
    logic [REG_W-1:0] hw_set;
    logic [REG_W-1:0] force_zero;
    logic [REG_W-1:0] state;

    // Pack the event pulses.
    always_comb begin
        ev.por    = ev_por;
        ev.bor    = ev_bor;
        ev.wdt    = ev_wdt;
        ev.sleep  = ev_sleep;
        ev.clrwdt = ev_clrwdt;
        ev.swrst  = ev_swrst;
        ev.cfgmis = ev_cfgmis;
    end

    rsc_event_map i_map (
        .ev         (ev),
        .vreg_en    (vreg_en),
        .hw_clr     (hw_clr),
        .hw_set     (hw_set),
        .force_zero (force_zero)
    );

    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        rsc_flag_cell #(
            .INIT (INIT_VAL[b]),
            .SW_W (SW_MASK[b]),
            .IMPL (IMPL_MASK[b])
        ) i_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .init       (ev.por),
            .force_zero (force_zero[b]),
            .hw_clr     (hw_clr[b]),
            .hw_set     (hw_set[b]),
            .sw_we      (wr_en),
            .sw_d       (wr_data[b]),
            .q          (state[b])
        );
    end

    rsc_readout i_rd (
        .state      (state),
        .vreg_en    (vreg_en),
        .rd_data    (rd_data),
        .prio_en_o  (prio_en_o),
        .brownout_o (brownout_o)
    );

endmodule

// File: rtl/rsc_status_chk.sv
// Checker: temporal properties of the reset cause status register, bound to its top.
module rsc_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ev_por,
    input logic       ev_bor,
    input logic       ev_wdt,
    input logic       ev_sleep,
    input logic       ev_clrwdt,
    input logic       ev_swrst,
    input logic       ev_cfgmis,
    input logic       vreg_en,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       prio_en_o,
    input logic       brownout_o
);

    assert_por_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ev_por |=> rd_data == 8'h3C);

    assert_bit6_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[6] == 1'b0);

    assert_prio_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ev_por) |=> (rd_data[7] == $past(wr_data[7])) && (prio_en_o == rd_data[7]));

    assert_cfg_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_cfgmis && !ev_por) |=> !rd_data[5]);

    assert_swrst_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_swrst && !ev_por) |=> !rd_data[4]);

    assert_wdt_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_wdt && !ev_por) |=> !rd_data[3]);

    assert_sleep_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_sleep && !ev_por) |=> !rd_data[2]);

    assert_ro_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ev_por && !ev_wdt && !ev_sleep && !ev_clrwdt)
        |=> rd_data[3:2] == $past(rd_data[3:2]));

    assert_bor_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_bor && !ev_por) |=> !rd_data[0]);

    assert_vreg_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !vreg_en |-> !rd_data[0]);

    assert_brownout_R11: assert property (@(posedge clk) disable iff (!rst_n)
        brownout_o == (!rd_data[0] && rd_data[1]));

    assert_idle_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !ev_por && !ev_bor && !ev_wdt && !ev_sleep && !ev_clrwdt
         && !ev_swrst && !ev_cfgmis && vreg_en) |=> $stable(rd_data[7:1]));

endmodule

bind rsc_status_reg rsc_status_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_por     (ev_por),
    .ev_bor     (ev_bor),
    .ev_wdt     (ev_wdt),
    .ev_sleep   (ev_sleep),
    .ev_clrwdt  (ev_clrwdt),
    .ev_swrst   (ev_swrst),
    .ev_cfgmis  (ev_cfgmis),
    .vreg_en    (vreg_en),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .prio_en_o  (prio_en_o),
    .brownout_o (brownout_o)
);

// File: tb/test_rsc_status_reg.sv
module test_rsc_status_reg;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_por = 0, ev_bor = 0, ev_wdt = 0, ev_sleep = 0;
    logic       ev_clrwdt = 0, ev_swrst = 0, ev_cfgmis = 0;
    logic       vreg_en = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       prio_en_o, brownout_o;

    always #10 clk = ~clk;

    rsc_status_reg i_rsc_status_reg (
        .clk(clk), .rst_n(rst_n), .ev_por(ev_por), .ev_bor(ev_bor),
        .ev_wdt(ev_wdt), .ev_sleep(ev_sleep), .ev_clrwdt(ev_clrwdt),
        .ev_swrst(ev_swrst), .ev_cfgmis(ev_cfgmis), .vreg_en(vreg_en),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .prio_en_o(prio_en_o), .brownout_o(brownout_o)
    );

    typedef struct {
        logic [7:0] rd;
        logic       prio;
        logic       bo;
        string      req;
    } exp_t;

    exp_t       sb[$];
    int         n_chk = 0;
    int         n_fail = 0;
    logic [7:0] mdl = 8'h3C;
    bit         done = 0;

    // Model from the requirements: expected stored value after one edge.
    function automatic logic [7:0] next_val(logic [7:0] s, logic [6:0] e, logic vr,
                                            logic we, logic [7:0] d);
        logic [7:0] n;
        // e = {por, bor, wdt, sleep, clrwdt, swrst, cfgmis}
        n = s;
        if (e[6]) return 8'h3C;                              // R1
        if (we) begin
            n[7] = d[7];                                     // R3
            n[5] = d[5]; n[4] = d[4];                        // R4 R5
            n[1] = d[1]; n[0] = d[0];                        // R9
        end
        if (e[2] | e[3]) n[3] = 1'b1;                        // R6 sets
        if (e[2])        n[2] = 1'b1;                        // R7 set
        if (e[4]) n[3] = 1'b0;                               // R6 clear wins
        if (e[3]) n[2] = 1'b0;                               // R7 clear wins
        if (e[0]) n[5] = 1'b0;                               // R4, R12
        if (e[1]) n[4] = 1'b0;                               // R5
        if (e[5]) n[0] = 1'b0;                               // R9
        if (!vr)  n[0] = 1'b0;                               // R10
        n[6] = 1'b0;                                         // R2
        return n;
    endfunction

    function automatic exp_t view(logic [7:0] s, logic vr, string req);
        exp_t x;
        x.rd    = s;
        x.rd[0] = s[0] & vr;
        x.rd[6] = 1'b0;
        x.prio  = x.rd[7];
        x.bo    = ~x.rd[0] & x.rd[1];                        // R11
        x.req   = req;
        return x;
    endfunction

    // Driver: apply one cycle of stimulus, then push the expected result.
    task automatic step(logic [6:0] e, logic vr, logic we, logic [7:0] d, string req);
        @(negedge clk); #1;
        {ev_por, ev_bor, ev_wdt, ev_sleep, ev_clrwdt, ev_swrst, ev_cfgmis} = e;
        vreg_en = vr; wr_en = we; wr_data = d;
        @(posedge clk); #1;
        mdl = next_val(mdl, e, vr, we, d);
        sb.push_back(view(mdl, vr, req));
        {ev_por, ev_bor, ev_wdt, ev_sleep, ev_clrwdt, ev_swrst, ev_cfgmis} = '0;
        wr_en = 1'b0;
    endtask

    // Monitor: compare each pending item at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t x;
                x = sb.pop_front();
                n_chk++;
                if (rd_data !== x.rd || prio_en_o !== x.prio || brownout_o !== x.bo) begin
                    n_fail++;
                    $display("FAIL %s: rd=%h prio=%b bo=%b expected rd=%h prio=%b bo=%b",
                             x.req, rd_data, prio_en_o, brownout_o, x.rd, x.prio, x.bo);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(20 * 5000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    localparam logic [6:0] E_NONE = 7'b000_0000, E_POR = 7'b100_0000, E_BOR = 7'b010_0000,
                           E_WDT = 7'b001_0000, E_SLP = 7'b000_1000, E_CLR = 7'b000_0100,
                           E_SWR = 7'b000_0010, E_CFG = 7'b000_0001;

    initial begin
        repeat (3) @(posedge clk);
        #1;
        sb.push_back(view(8'h3C, 1'b1, "R1 reset"));
        @(negedge clk); #2;
        rst_n = 1'b1;
        step(E_NONE, 1, 1, 8'hFF, "R2 R3 R8 R9 write all ones");        // BF
        step(E_BOR,  1, 0, 8'h00, "R9 R11 brown-out event");            // BE
        step(E_NONE, 1, 1, 8'h00, "R8 write zeros");                    // 0C
        step(E_NONE, 1, 1, 8'hFF, "R4 R5 re-arm");                      // BF
        step(E_SLP,  1, 0, 8'h00, "R7 sleep");                          // BB
        step(E_WDT,  1, 0, 8'h00, "R6 watchdog expiry");                // B3
        step(E_CLR,  1, 0, 8'h00, "R6 R7 watchdog restart");            // BF
        step(E_WDT | E_CLR, 1, 0, 8'h00, "R6 clear wins over set");     // B7
        step(E_SLP | E_CLR, 1, 0, 8'h00, "R7 clear wins over set");     // BB
        step(E_CFG,  1, 1, 8'hFF, "R12 R4 clear beats write");          // 9B
        step(E_SWR,  1, 0, 8'h00, "R5 reset instruction");              // 8B
        step(E_NONE, 1, 1, 8'hFF, "R4 R5 software sets");               // BB
        step(E_NONE, 0, 0, 8'h00, "R10 R11 regulator off");             // BA
        step(E_NONE, 0, 1, 8'hFF, "R10 write ignored while off");       // BA
        step(E_NONE, 1, 0, 8'h00, "R10 stays low after re-enable");     // BA
        step(E_NONE, 1, 1, 8'hBB, "R9 R11 software sets brown-out");    // BB
        step(E_NONE, 1, 0, 8'h00, "R13 idle hold");                     // BB
        step(E_POR,  1, 1, 8'hFF, "R1 power-on overrides write");       // 3C
        step(E_NONE, 1, 1, 8'h40, "R2 bit 6 write ignored");            // 0C
        step(E_NONE, 1, 1, 8'h02, "R9 R11 power-on flag set");          // 0E
        step(E_NONE, 1, 0, 8'h00, "R13 idle hold again");               // 0E
        repeat (3) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule